// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of a single-data-rate SDRAM and samples them on every rising clock edge: clock enable, chip select, the row, column and write strobes, the bank address and address bit 10. It turns each sample into one command code. For every bank it runs a state machine that follows the command stream: it opens rows, runs bursts, closes rows with precharge, and goes through the timed states for row-to-column delay, precharge time and write recovery. A command that the addressed bank (or the device as a whole) may not take in its present state is reported as illegal and has no effect.

It is meant to sit beside a memory controller or a memory model as a protocol monitor. The decoded command, a per-bank state vector, a self-refresh flag and an illegal-command flag all come out of registers. They are updated on the same edge that samples the pins. Address bit 10 has two uses: on a read or a write it asks for auto-precharge, and on a precharge it selects every bank.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: During reset, and right after it, `cmd_o` reads 1 (NOP), `illegal_o` and `self_ref_o` are 0, and every bank state is 0 (idle).
- R2: Each rising edge produces one command code in `cmd_o` and a flag in `illegal_o`, both valid after that edge. If the previous edge saw clock enable high and `cs_n` is high, the code is 0. With `cs_n` low, the strobe pattern {ras_n,cas_n,we_n} is decoded as follows: 111 gives 1 (NOP), 011 gives 2 (ACT), 101 gives 3 (READ), 100 gives 5 (WRITE), 010 gives 7 (PRE), 001 with `cke` high gives 9 (auto-refresh), 001 with `cke` low gives 10 (self-refresh entry), 000 gives 12 (mode set) and 110 gives 13 (burst stop).
- R3: When `a10` is high, READ becomes 4 and WRITE becomes 6, both with auto-precharge. PRE becomes 8, which closes every bank that is in state 2, 3 or 4 and leaves idle banks as they are.
- R4: ACT to an idle bank sets the bank to state 1 (opening) for T_RCD edges. After that the bank is in state 2 (open).
- R5: For an idle bank, READ, WRITE and burst stop are illegal, and PRE is legal but changes nothing.
- R6: A bank in state 1, 7 (write recovery) or 8 (closing) rejects every command addressed to it. All-bank precharge is illegal while any bank is in state 1, 5, 6, 7 or 8.
- R7: READ or WRITE to a bank in state 2 starts a plain burst, state 3 (read) or 4 (write), for BURST_LEN edges, after which the bank returns to 2. During a plain burst, a new READ or WRITE restarts it and burst stop returns the bank to 2. A READ or WRITE to another bank also returns this bank to 2.
- R8: An auto-precharge burst, state 5 (read) or 6 (write), runs for BURST_LEN edges. While it runs, READ, WRITE, burst stop and PRE to that bank are illegal, and so are READ and WRITE to any other bank. Afterwards a read moves to 8, and a write moves to 7 for T_WR edges and then to 8.
- R9: PRE to a bank in state 2, 3 or 4 sets it to 8 for T_RP edges. The bank then becomes 0.
- R10: Auto-refresh, self-refresh entry and mode set are legal only when every bank is 0. They change no bank state.
- R11: A legal self-refresh entry sets `self_ref_o`. While `cke` stays low, `cmd_o` reads 14 and the pins have no effect. The first edge with `cke` high gives code 11 and clears `self_ref_o`.
- R12: ACT to a bank that is not idle is illegal. A command flagged illegal changes no bank state, although running timers still advance.
- R13: Outside self-refresh, if the previous edge sampled `cke` low, the code is 15 and the pins have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Precharge-all / auto-precharge select |
| cmd_o | output | 4 | Decoded command code |
| illegal_o | output | 1 | Previous command was rejected |
| self_ref_o | output | 1 | Device is in self-refresh |
| bank_state_o | output | 4*NUM_BANKS | Bank b state in bits [4b+3:4b] |

## Verification
The command code and the illegal flag are due at the first rising edge after the pins are presented. A bank's new state is visible after that same edge. A timed state entered on edge k is left on edge k+N, where N is its parameter. The bench drives the pins on the falling edge, and its reference model advances on the rising edge from the same sampled pins. It compares all outputs on the next falling edge, so every result is read exactly one edge after its stimulus. Hand-written checks then count the falling edges up to each timed exit.

// File: rtl/sdtrk_pkg.sv
package sdtrk_pkg;

  typedef enum logic [3:0] {
    C_DESEL  = 4'd0,  C_NOP   = 4'd1,  C_ACT   = 4'd2,  C_RD    = 4'd3,
    C_RDA    = 4'd4,  C_WR    = 4'd5,  C_WRA   = 4'd6,  C_PRE   = 4'd7,
    C_PREA   = 4'd8,  C_REFA  = 4'd9,  C_SREF  = 4'd10, C_SREFX = 4'd11,
    C_MRS    = 4'd12, C_TBST  = 4'd13, C_SLEEP = 4'd14, C_CKSTOP = 4'd15
  } cmd_t;

  typedef enum logic [3:0] {
    B_IDLE = 4'd0, B_OPENING = 4'd1, B_OPEN = 4'd2, B_RD = 4'd3, B_WR = 4'd4,
    B_RDAP = 4'd5, B_WRAP = 4'd6, B_WREC = 4'd7, B_CLOSING = 4'd8
  } bank_st_t;

  typedef enum logic [2:0] {
    A_HOLD, A_OPEN, A_RD, A_RDA, A_WR, A_WRA, A_CLOSE, A_STOP
  } bank_act_t;

  function automatic cmd_t decode_pins(input logic cke_prev, input logic cke_now,
                                       input logic asleep, input logic cs_n,
                                       input logic ras_n, input logic cas_n,
                                       input logic we_n, input logic a10);
    if (asleep) return cke_now ? C_SREFX : C_SLEEP;
    if (!cke_prev) return C_CKSTOP;
    if (cs_n) return C_DESEL;
    case ({ras_n, cas_n, we_n})
      3'b111:  return C_NOP;
      3'b011:  return C_ACT;
      3'b101:  return a10 ? C_RDA : C_RD;
      3'b100:  return a10 ? C_WRA : C_WR;
      3'b010:  return a10 ? C_PREA : C_PRE;
      3'b001:  return cke_now ? C_REFA : C_SREF;
      3'b000:  return C_MRS;
      default: return C_TBST;
    endcase
  endfunction

  function automatic logic in_plain_burst(input bank_st_t s);
    return (s == B_RD) || (s == B_WR);
  endfunction

  function automatic logic in_ap_burst(input bank_st_t s);
    return (s == B_RDAP) || (s == B_WRAP);
  endfunction

  function automatic logic is_locked(input bank_st_t s);
    return (s == B_OPENING) || (s == B_WREC) || (s == B_CLOSING) || in_ap_burst(s);
  endfunction

  function automatic logic can_close(input bank_st_t s);
    return (s == B_OPEN) || in_plain_burst(s);
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sdtrk_decode.sv
module sdtrk_decode
  import sdtrk_pkg::*;
(
  input  logic cke_prev,
  input  logic cke,
  input  logic asleep,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  output cmd_t cmd
);
  always_comb begin
    cmd = decode_pins(cke_prev, cke, asleep, cs_n, ras_n, cas_n, we_n, a10);
  end
endmodule

// File: rtl/sdtrk_judge.sv
module sdtrk_judge
  import sdtrk_pkg::*;
#(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input  cmd_t                 cmd,
  input  logic [BA_W-1:0]      ba,
  input  bank_st_t [NB-1:0]    st,
  output logic                 legal,
  output bank_act_t [NB-1:0]   act
);
  bank_st_t  tgt;
  logic      all_idle;
  logic      any_locked;
  logic      other_ap;
  bank_act_t raw [NB];

  always_comb begin
    tgt        = st[ba];
    all_idle   = 1'b1;
    any_locked = 1'b0;
    other_ap   = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (st[b] != B_IDLE) all_idle = 1'b0;
      if (is_locked(st[b])) any_locked = 1'b1;
      if ((b != int'(ba)) && in_ap_burst(st[b])) other_ap = 1'b1;
    end
  end

  always_comb begin
    legal = 1'b1;
    for (int b = 0; b < NB; b++) raw[b] = A_HOLD;
    case (cmd)
      C_ACT: begin
        if (tgt == B_IDLE) raw[ba] = A_OPEN;
        else legal = 1'b0;
      end
      C_RD, C_RDA, C_WR, C_WRA: begin
        if (((tgt == B_OPEN) || in_plain_burst(tgt)) && !other_ap) begin
          for (int b = 0; b < NB; b++)
            if (in_plain_burst(st[b])) raw[b] = A_STOP;
          case (cmd)
            C_RD:    raw[ba] = A_RD;
            C_RDA:   raw[ba] = A_RDA;
            C_WR:    raw[ba] = A_WR;
            default: raw[ba] = A_WRA;
          endcase
        end else begin
          legal = 1'b0;
        end
      end
      C_PRE: begin
        if (can_close(tgt)) raw[ba] = A_CLOSE;
        else if (tgt != B_IDLE) legal = 1'b0;
      end
      C_PREA: begin
        if (any_locked) legal = 1'b0;
        else
          for (int b = 0; b < NB; b++)
            if (can_close(st[b])) raw[b] = A_CLOSE;
      end
      C_TBST: begin
        if (in_plain_burst(tgt)) raw[ba] = A_STOP;
        else if (tgt != B_OPEN) legal = 1'b0;
      end
      C_REFA, C_SREF, C_MRS: legal = all_idle;
      default: legal = 1'b1;
    endcase
  end

  always_comb begin
    for (int b = 0; b < NB; b++) act[b] = legal ? raw[b] : A_HOLD;
  end
endmodule

// File: rtl/sdtrk_bank.sv
module sdtrk_bank
  import sdtrk_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4,
  parameter int CW        = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  bank_act_t act,
  output bank_st_t  st
);
  localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] LD_WR  = CW'(T_WR - 1);
  localparam logic [CW-1:0] LD_BL  = CW'(BURST_LEN - 1);

  logic [CW-1:0] cnt;
  logic          expired;

  assign expired = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= B_IDLE;
      cnt <= '0;
    end else begin
      case (act)
        A_OPEN:  begin st <= B_OPENING; cnt <= LD_RCD; end
        A_RD:    begin st <= B_RD;      cnt <= LD_BL;  end
        A_RDA:   begin st <= B_RDAP;    cnt <= LD_BL;  end
        A_WR:    begin st <= B_WR;      cnt <= LD_BL;  end
        A_WRA:   begin st <= B_WRAP;    cnt <= LD_BL;  end
        A_CLOSE: begin st <= B_CLOSING; cnt <= LD_RP;  end
        A_STOP:  begin st <= B_OPEN;    cnt <= '0;     end
        default: begin
          if (st != B_IDLE && st != B_OPEN) begin
            if (!expired) begin
              cnt <= cnt - 1'b1;
            end else begin
              case (st)
                B_OPENING, B_RD, B_WR: st <= B_OPEN;
                B_RDAP:  begin st <= B_CLOSING; cnt <= LD_RP; end
                B_WRAP:  begin st <= B_WREC;    cnt <= LD_WR; end
                B_WREC:  begin st <= B_CLOSING; cnt <= LD_RP; end
                default: st <= B_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdtrk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BA_W-1:0]        ba,
  input  logic                   a10,
  output logic [3:0]             cmd_o,
  output logic                   illegal_o,
  output logic                   self_ref_o,
  output logic [4*NUM_BANKS-1:0] bank_state_o
);
  localparam int MAXT = max4(T_RCD, T_RP, T_WR, BURST_LEN);
  localparam int CW   = $clog2(MAXT + 1);

  logic                     cke_q;
  logic                     sleep_q;
  cmd_t                     cur_cmd;
  logic                     cmd_legal;
  logic                     sleep_enter;
  logic                     sleep_leave;
  bank_act_t [NUM_BANKS-1:0] bank_act;
  bank_st_t  [NUM_BANKS-1:0] bank_st;
  cmd_t                     cmd_q;
  logic                     ill_q;

  sdtrk_decode u_decode (
    .cke_prev (cke_q),
    .cke      (cke),
    .asleep   (sleep_q),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .a10      (a10),
    .cmd      (cur_cmd)
  );

  sdtrk_judge #(.NB(NUM_BANKS), .BA_W(BA_W)) u_judge (
    .cmd   (cur_cmd),
    .ba    (ba),
    .st    (bank_st),
    .legal (cmd_legal),
    .act   (bank_act)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdtrk_bank #(
      .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR), .BURST_LEN(BURST_LEN), .CW(CW)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (bank_act[g]),
      .st    (bank_st[g])
    );
    assign bank_state_o[4*g +: 4] = bank_st[g];
  end

  assign sleep_enter = (cur_cmd == C_SREF) && cmd_legal;
  assign sleep_leave = (cur_cmd == C_SREFX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q   <= 1'b1;
      sleep_q <= 1'b0;
      cmd_q   <= C_NOP;
      ill_q   <= 1'b0;
    end else begin
      cke_q <= cke;
      cmd_q <= cur_cmd;
      ill_q <= !cmd_legal;
      if (sleep_enter)      sleep_q <= 1'b1;
      else if (sleep_leave) sleep_q <= 1'b0;
    end
  end

  assign cmd_o      = cmd_q;
  assign illegal_o  = ill_q;
  assign self_ref_o = sleep_q;
endmodule

// File: rtl/sdtrk_checker.sv
module sdtrk_checker #(
  parameter int NUM_BANKS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [3:0]             cmd_o,
  input logic                   illegal_o,
  input logic                   self_ref_o,
  input logic [4*NUM_BANKS-1:0] bank_state_o
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
    a_r4_opening_ends_open: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bank_state_o[4*g +: 4]) == 4'd1 && bank_state_o[4*g +: 4] != 4'd1)
        |-> bank_state_o[4*g +: 4] == 4'd2);
    a_r8_read_ap_to_closing: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bank_state_o[4*g +: 4]) == 4'd5 && bank_state_o[4*g +: 4] != 4'd5)
        |-> bank_state_o[4*g +: 4] == 4'd8);
    a_r8_write_ap_to_recovery: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bank_state_o[4*g +: 4]) == 4'd6 && bank_state_o[4*g +: 4] != 4'd6)
        |-> bank_state_o[4*g +: 4] == 4'd7);
    a_r9_closing_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bank_state_o[4*g +: 4]) == 4'd8 && bank_state_o[4*g +: 4] != 4'd8)
        |-> bank_state_o[4*g +: 4] == 4'd0);
    a_r12_illegal_keeps_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal_o && $past(bank_state_o[4*g +: 4]) == 4'd0)
        |-> bank_state_o[4*g +: 4] == 4'd0);
  end

  a_r10_refresh_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o == 4'd9 || cmd_o == 4'd10 || cmd_o == 4'd12) && !illegal_o)
      |-> $past(bank_state_o) == '0);

  a_r11_sleep_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (self_ref_o && $past(self_ref_o)) |-> $stable(bank_state_o));

  a_r11_sleep_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(self_ref_o) |-> (cmd_o == 4'd10 && !illegal_o));
endmodule

bind sdram_cmd_tracker sdtrk_checker #(.NUM_BANKS(NUM_BANKS)) u_sdtrk_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_o        (cmd_o),
  .illegal_o    (illegal_o),
  .self_ref_o   (self_ref_o),
  .bank_state_o (bank_state_o)
);

// File: tb/test_sdram_cmd_tracker.sv
`timescale 1ns/1ps
module test_sdram_cmd_tracker;
  localparam int NB  = 4;
  localparam int TRCD = 3;
  localparam int TRP  = 3;
  localparam int TWR  = 2;
  localparam int BL   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d_cke = 1'b1, d_cs = 1'b0, d_ras = 1'b1, d_cas = 1'b1, d_we = 1'b1, d_a10 = 1'b0;
  logic [1:0] d_ba = 2'd0;
  logic [3:0] cmd_o;
  logic illegal_o, self_ref_o;
  logic [4*NB-1:0] bank_state_o;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  string m_req = "R1";

  // reference model state
  int  ms [NB];
  int  mr [NB];
  bit  msleep = 0;
  bit  mckeq = 1;
  int  mcmd = 1;
  bit  mill = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker #(.NUM_BANKS(NB), .T_RCD(TRCD), .T_RP(TRP), .T_WR(TWR),
                      .BURST_LEN(BL)) i_sdram_cmd_tracker (
    .clk(clk), .rst_n(rst_n), .cke(d_cke), .cs_n(d_cs), .ras_n(d_ras),
    .cas_n(d_cas), .we_n(d_we), .ba(d_ba), .a10(d_a10),
    .cmd_o(cmd_o), .illegal_o(illegal_o), .self_ref_o(self_ref_o),
    .bank_state_o(bank_state_o)
  );

  function automatic int bst(input int b);
    return int'(bank_state_o[4*b +: 4]);
  endfunction

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // advance one timed bank by one edge
  task automatic tick(input int s, input int r, output int ns, output int nr);
    ns = s; nr = r;
    if (s != 0 && s != 2) begin
      nr = r - 1;
      if (nr == 0) begin
        if (s == 1 || s == 3 || s == 4) ns = 2;
        else if (s == 5 || s == 7) begin ns = 8; nr = TRP; end
        else if (s == 6) begin ns = 7; nr = TWR; end
        else ns = 0;
      end
    end
  endtask

  task automatic model_step();
    int c; bit ok; int t; bit idle_all, locked_any, ap_other;
    int ns [NB]; int nr [NB];
    if (msleep) c = d_cke ? 11 : 14;
    else if (!mckeq) c = 15;
    else if (d_cs) c = 0;
    else begin
      case ({d_ras, d_cas, d_we})
        3'b111: c = 1;
        3'b011: c = 2;
        3'b101: c = d_a10 ? 4 : 3;
        3'b100: c = d_a10 ? 6 : 5;
        3'b010: c = d_a10 ? 8 : 7;
        3'b001: c = d_cke ? 9 : 10;
        3'b000: c = 12;
        default: c = 13;
      endcase
    end
    for (int b = 0; b < NB; b++) tick(ms[b], mr[b], ns[b], nr[b]);
    t = int'(d_ba);
    idle_all = 1; locked_any = 0; ap_other = 0;
    for (int b = 0; b < NB; b++) begin
      if (ms[b] != 0) idle_all = 0;
      if (ms[b] inside {1, 5, 6, 7, 8}) locked_any = 1;
      if (b != t && ms[b] inside {5, 6}) ap_other = 1;
    end
    ok = 1;
    case (c)
      2: if (ms[t] == 0) begin ns[t] = 1; nr[t] = TRCD; end else ok = 0;
      3, 4, 5, 6: begin
        if (ms[t] inside {2, 3, 4} && !ap_other) begin
          for (int b = 0; b < NB; b++) if (ms[b] inside {3, 4}) ns[b] = 2;
          ns[t] = (c == 3) ? 3 : (c == 4) ? 5 : (c == 5) ? 4 : 6;
          nr[t] = BL;
        end else ok = 0;
      end
      7: begin
        if (ms[t] inside {2, 3, 4}) begin ns[t] = 8; nr[t] = TRP; end
        else if (ms[t] != 0) ok = 0;
      end
      8: begin
        if (locked_any) ok = 0;
        else for (int b = 0; b < NB; b++)
          if (ms[b] inside {2, 3, 4}) begin ns[b] = 8; nr[b] = TRP; end
      end
      13: begin
        if (ms[t] inside {3, 4}) ns[t] = 2;
        else if (ms[t] != 2) ok = 0;
      end
      9, 10, 12: ok = idle_all;
      default: ok = 1;
    endcase
    if (ok) begin
      for (int b = 0; b < NB; b++) begin ms[b] = ns[b]; mr[b] = nr[b]; end
    end else begin
      // rejected command: only the running timers move
      for (int b = 0; b < NB; b++) begin
        int ts; int tr;
        tick(ms[b], mr[b], ts, tr);
        ms[b] = ts; mr[b] = tr;
      end
    end
    if (c == 10 && ok) msleep = 1;
    else if (c == 11) msleep = 0;
    mckeq = d_cke;
    mcmd = c;
    mill = !ok;
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      m_req = cur_req;
      model_step();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(m_req, "cmd_o", int'(cmd_o), mcmd);
      check(m_req, "illegal_o", int'(illegal_o), int'(mill));
      check(m_req, "self_ref_o", int'(self_ref_o), int'(msleep));
      for (int b = 0; b < NB; b++) check(m_req, $sformatf("bank%0d", b), bst(b), ms[b]);
    end
  end

  task automatic drive(input string req, input bit cs, input bit ras, input bit cas,
                       input bit we, input int b, input bit a, input bit ck);
    cur_req = req;
    d_cs = cs; d_ras = ras; d_cas = cas; d_we = we; d_ba = 2'(b); d_a10 = a; d_cke = ck;
    @(negedge clk);
  endtask

  task automatic nop(input string req, input int n);
    for (int i = 0; i < n; i++) drive(req, 0, 1, 1, 1, 0, 0, 1);
  endtask
  task automatic act(input string req, input int b);     drive(req, 0, 0, 1, 1, b, 0, 1); endtask
  task automatic rd(input string req, input int b, input bit ap);  drive(req, 0, 1, 0, 1, b, ap, 1); endtask
  task automatic wr(input string req, input int b, input bit ap);  drive(req, 0, 1, 0, 0, b, ap, 1); endtask
  task automatic pre(input string req, input int b, input bit all); drive(req, 0, 0, 1, 0, b, all, 1); endtask
  task automatic tbst(input string req, input int b);    drive(req, 0, 1, 1, 0, b, 0, 1); endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin ms[b] = 0; mr[b] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "cmd_o", int'(cmd_o), 1);
    check("R1", "illegal_o", int'(illegal_o), 0);
    check("R1", "self_ref_o", int'(self_ref_o), 0);
    check("R1", "bank_state_o", int'(bank_state_o), 0);
    rst_n = 1'b1;
    check("R1", "cmd_o after release", int'(cmd_o), 1);

    // R2: deselect and NOP
    drive("R2", 1, 0, 0, 0, 3, 1, 1);
    check("R2", "deselect code", int'(cmd_o), 0);
    nop("R2", 1);
    check("R2", "nop code", int'(cmd_o), 1);

    // R5: idle bank
    rd("R5", 0, 0);
    check("R5", "read to idle flagged", int'(illegal_o), 1);
    pre("R5", 0, 0);
    check("R5", "pre to idle code", int'(cmd_o), 7);
    check("R5", "pre to idle legal", int'(illegal_o), 0);
    tbst("R5", 0);
    check("R5", "stop to idle flagged", int'(illegal_o), 1);

    // R4 / R12: open a row
    act("R4", 0);
    check("R4", "bank0 opening", bst(0), 1);
    act("R12", 0);
    check("R12", "second act flagged", int'(illegal_o), 1);
    check("R12", "bank0 still opening", bst(0), 1);
    nop("R4", 1);
    check("R4", "bank0 opening at tRCD-1", bst(0), 1);
    nop("R4", 1);
    check("R4", "bank0 open at tRCD", bst(0), 2);

    // R7: plain bursts
    rd("R7", 0, 0);
    check("R7", "bank0 reading", bst(0), 3);
    nop("R7", 1);
    wr("R7", 0, 0);
    check("R7", "bank0 writing", bst(0), 4);
    tbst("R7", 0);
    check("R7", "burst stop", bst(0), 2);
    rd("R7", 0, 0);
    nop("R7", BL);
    check("R7", "burst ended", bst(0), 2);

    // R9: close
    pre("R9", 0, 0);
    check("R9", "bank0 closing", bst(0), 8);
    nop("R9", TRP - 1);
    check("R9", "bank0 closing at tRP-1", bst(0), 8);
    nop("R9", 1);
    check("R9", "bank0 idle", bst(0), 0);

    // R6: locked opening bank
    act("R6", 1);
    pre("R6", 1, 0);
    check("R6", "pre to opening flagged", int'(illegal_o), 1);
    nop("R6", 2);
    check("R6", "bank1 open", bst(1), 2);

    // R8: read with auto-precharge
    act("R8", 0);
    nop("R8", TRCD);
    rd("R8", 1, 1);
    check("R8", "read-ap code", int'(cmd_o), 4);
    check("R8", "bank1 read-ap", bst(1), 5);
    rd("R8", 0, 0);
    check("R8", "read to other bank flagged", int'(illegal_o), 1);
    tbst("R8", 1);
    check("R8", "stop flagged", int'(illegal_o), 1);
    pre("R8", 1, 0);
    check("R8", "pre flagged", int'(illegal_o), 1);
    nop("R8", 1);
    check("R8", "bank1 closing", bst(1), 8);
    nop("R8", TRP);
    check("R8", "bank1 idle", bst(1), 0);

    // R8: write with auto-precharge
    wr("R8", 0, 1);
    check("R3", "write-ap code", int'(cmd_o), 6);
    nop("R8", BL);
    check("R8", "bank0 write recovery", bst(0), 7);
    nop("R8", TWR);
    check("R8", "bank0 closing", bst(0), 8);
    nop("R8", TRP);
    check("R8", "bank0 idle", bst(0), 0);

    // R3: precharge all
    act("R3", 0);
    act("R3", 1);
    nop("R3", TRCD);
    rd("R3", 1, 0);
    pre("R3", 2, 1);
    check("R3", "all-bank code", int'(cmd_o), 8);
    check("R3", "bank0 closing", bst(0), 8);
    check("R3", "bank1 closing", bst(1), 8);
    check("R3", "bank2 idle", bst(2), 0);
    nop("R3", TRP);
    act("R6", 3);
    pre("R6", 0, 1);
    check("R6", "all-bank with opening bank flagged", int'(illegal_o), 1);
    nop("R6", TRCD);

    // R10: refresh and mode set
    drive("R10", 0, 0, 0, 1, 0, 0, 1);
    check("R10", "refresh with open bank flagged", int'(illegal_o), 1);
    pre("R10", 3, 0);
    nop("R10", TRP);
    drive("R10", 0, 0, 0, 1, 0, 0, 1);
    check("R10", "refresh code", int'(cmd_o), 9);
    check("R10", "refresh legal", int'(illegal_o), 0);
    drive("R10", 0, 0, 0, 0, 0, 0, 1);
    check("R10", "mode set code", int'(cmd_o), 12);

    // R11: self-refresh
    drive("R11", 0, 0, 0, 1, 0, 0, 0);
    check("R11", "entry code", int'(cmd_o), 10);
    check("R11", "self_ref set", int'(self_ref_o), 1);
    for (int i = 0; i < 3; i++) drive("R11", 0, 0, 1, 1, i, 0, 0);
    check("R11", "sleep code", int'(cmd_o), 14);
    check("R11", "act ignored", bst(2), 0);
    drive("R11", 0, 1, 1, 1, 0, 0, 1);
    check("R11", "exit code", int'(cmd_o), 11);
    check("R11", "self_ref cleared", int'(self_ref_o), 0);
    nop("R11", 1);

    // R13: clock enable low outside self-refresh
    drive("R13", 0, 0, 1, 1, 2, 0, 0);
    check("R13", "act with cke falling accepted", bst(2), 1);
    drive("R13", 0, 0, 1, 1, 3, 0, 0);
    check("R13", "suspended code", int'(cmd_o), 15);
    check("R13", "act ignored", bst(3), 0);
    drive("R13", 0, 0, 1, 1, 3, 0, 1);
    check("R13", "still suspended", int'(cmd_o), 15);
    nop("R13", TRCD);
    act("R12", 2);
    check("R12", "act to open bank flagged", int'(illegal_o), 1);
    pre("R12", 2, 0);
    nop("R12", TRP);

    // mixed random traffic, compared cycle by cycle against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      drive("R12", (r < 8), 1'($urandom), 1'($urandom), 1'($urandom),
            int'($urandom_range(0, 3)), ($urandom_range(0, 9) < 3),
            ($urandom_range(0, 19) != 0));
    end
    drive("R11", 0, 1, 1, 1, 0, 0, 1);
    nop("R12", 12);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule